// File: doc/BRIEF.md
# Vectored 64-Source Interrupt Controller

This block collects 64 level-sensitive interrupt lines for a single core and raises one request line toward it. Each of the 64 priority channels takes its input from a source chosen by a programmable one-byte selector, so software can reroute any physical line to any channel. A per-channel enable gates the channel. A software force register can drive any source high as if its line were asserted. Among the enabled channels that are pending, the lowest-numbered channel wins.

The core reads a status word at offset 0x00. It holds a pending flag. When the auto-vector control bit is set, it also holds the winning channel number, which the core uses as its vector index. Writes to the same offset set the control bit. All registers sit on a plain 32-bit register bus. Writes take effect on the clock edge where the write strobe is high. Reads are combinational from the address.

Top module: `irqv_ctrl`

## Requirements
- R1: After reset all enables, all force bits and the auto-vector bit are 0, `irq_req` is 0, and every channel c selects source c. As a result, the selector word at 0x40+4k reads {4k+3, 4k+2, 4k+1, 4k} from the top byte down.
- R2: The enable register at 0x10 holds channels 0..31 and the one at 0x28 holds channels 32..63. Bit i of each register maps to channel i of its half, and both registers read back as written. A channel whose enable is 0 never causes a request.
- R3: `irq_req` is 1 in the cycle after some enabled channel has its selected source high. It is 0 in the cycle after no such channel remains.
- R4: A read of 0x00 returns the auto-vector bit in bit 31 and the registered pending flag in bit 8. Bits 5:0 hold the winning channel number when auto-vector is 1, and read 0 when it is 0. All other bits read 0.
- R5: A write to 0x00 loads the auto-vector bit from bit 31 of the write data. The bit keeps its value when no such write occurs.
- R6: When several enabled channels are pending, the lowest channel number is reported.
- R7: In the selector word at 0x40+4k, byte b (bits 8b+7:8b) belongs to channel 4k+b, and its bits 5:0 pick the source that drives that channel. Bits 7:6 of each byte are dropped on write and read back as 0.
- R8: The force register at 0x08 (sources 0..31) and the one at 0x20 (sources 32..63) read back as written. A force bit set to 1 makes its source count as high until it is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_addr | input | 8 | Register byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq_src | input | 64 | Level-sensitive interrupt lines |
| irq_req | output | 1 | Interrupt request to the core |

## Verification
The bench goes after the remapping path. It moves channel 9 onto source 63 and then checks two things: raising source 63 gives vector 9, and raising source 9 gives no request. A design that prioritised raw sources, or indexed enables by source instead of by channel, would fail one of these. It also peels pending channels off one at a time to catch a priority encoder that favours the highest channel. It drops a line and checks that the request falls on the next cycle, which catches a design that latches requests as edges. A forced source is checked at channel 40 to catch a force register wired to the wrong half.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
  localparam int unsigned NSRC     = 64;
  localparam int unsigned SEL_W    = $clog2(NSRC);
  localparam int unsigned ADDR_W   = 8;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned HALF     = NSRC / 2;
  localparam int unsigned MAP_WORDS = NSRC / 4;
  localparam int unsigned AV_BIT   = 31;
  localparam int unsigned PEND_BIT = 8;

  localparam logic [ADDR_W-1:0] A_CTRL   = 8'h00;
  localparam logic [ADDR_W-1:0] A_FRC_LO = 8'h08;
  localparam logic [ADDR_W-1:0] A_EN_LO  = 8'h10;
  localparam logic [ADDR_W-1:0] A_FRC_HI = 8'h20;
  localparam logic [ADDR_W-1:0] A_EN_HI  = 8'h28;
  localparam logic [ADDR_W-1:0] A_MAP    = 8'h40;
endpackage

// File: rtl/irqv_regs.sv
module irqv_regs
  import irqv_pkg::*;
#(
  parameter int unsigned N  = NSRC,
  parameter int unsigned SW = SEL_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [DATA_W-1:0]     wdata,
  input  logic                  pend_i,
  input  logic [SW-1:0]         id_i,
  output logic [DATA_W-1:0]     rdata,
  output logic [N-1:0]          en_o,
  output logic [N-1:0]          frc_o,
  output logic                  av_o,
  output logic [N*SW-1:0]       map_o
);
  localparam int unsigned H  = N / 2;
  localparam int unsigned NW = N / 4;

  logic [N-1:0]  en_q,  en_d;
  logic [N-1:0]  frc_q, frc_d;
  logic          av_q,  av_d;
  logic [SW-1:0] map_q [N];
  logic [SW-1:0] map_d [N];

  // next state
  always_comb begin
    en_d  = en_q;
    frc_d = frc_q;
    av_d  = av_q;
    for (int c = 0; c < N; c++) map_d[c] = map_q[c];
    if (addr == A_CTRL)   av_d = wdata[AV_BIT];
    if (addr == A_EN_LO)  en_d[H-1:0]  = wdata[H-1:0];
    if (addr == A_EN_HI)  en_d[N-1:H]  = wdata[H-1:0];
    if (addr == A_FRC_LO) frc_d[H-1:0] = wdata[H-1:0];
    if (addr == A_FRC_HI) frc_d[N-1:H] = wdata[H-1:0];
    for (int w = 0; w < NW; w++) begin
      if (addr == ADDR_W'(int'(A_MAP) + 4 * w)) begin
        for (int b = 0; b < 4; b++) map_d[4*w+b] = wdata[8*b +: SW];
      end
    end
  end

  // registers, clock enable = write strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      frc_q <= '0;
      av_q  <= 1'b0;
      for (int c = 0; c < N; c++) map_q[c] <= SW'(c);
    end else if (wr_en) begin
      en_q  <= en_d;
      frc_q <= frc_d;
      av_q  <= av_d;
      for (int c = 0; c < N; c++) map_q[c] <= map_d[c];
    end
  end

  // read mux
  always_comb begin
    rdata = '0;
    if (addr == A_CTRL) begin
      rdata[AV_BIT]   = av_q;
      rdata[PEND_BIT] = pend_i;
      if (av_q) rdata[SW-1:0] = id_i;
    end
    if (addr == A_EN_LO)  rdata[H-1:0] = en_q[H-1:0];
    if (addr == A_EN_HI)  rdata[H-1:0] = en_q[N-1:H];
    if (addr == A_FRC_LO) rdata[H-1:0] = frc_q[H-1:0];
    if (addr == A_FRC_HI) rdata[H-1:0] = frc_q[N-1:H];
    for (int w = 0; w < NW; w++) begin
      if (addr == ADDR_W'(int'(A_MAP) + 4 * w)) begin
        for (int b = 0; b < 4; b++) rdata[8*b +: SW] = map_q[4*w+b];
      end
    end
  end

  assign en_o  = en_q;
  assign frc_o = frc_q;
  assign av_o  = av_q;

  generate
    for (genvar c = 0; c < N; c++) begin : g_map_out
      assign map_o[c*SW +: SW] = map_q[c];
    end
  endgenerate

  // R5: auto-vector bit changes only through a control write
  assert_av_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == A_CTRL) |=> $stable(av_q));
endmodule

// File: rtl/irqv_route.sv
module irqv_route
  import irqv_pkg::*;
#(
  parameter int unsigned N  = NSRC,
  parameter int unsigned SW = SEL_W
) (
  input  logic [N-1:0]    src,
  input  logic [N*SW-1:0] map,
  input  logic [N-1:0]    en,
  output logic [N-1:0]    chan_pend
);
  generate
    for (genvar c = 0; c < N; c++) begin : g_chan
      assign chan_pend[c] = en[c] & src[map[c*SW +: SW]];
    end
  endgenerate
endmodule

// File: rtl/irqv_pick.sv
module irqv_pick
  import irqv_pkg::*;
#(
  parameter int unsigned N  = NSRC,
  parameter int unsigned SW = SEL_W
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [SW-1:0] id
);
  always_comb begin
    id = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) id = SW'(i);
    end
  end
  assign any = |req;
endmodule

// File: rtl/irqv_ctrl.sv
module irqv_ctrl
  import irqv_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NSRC-1:0]   irq_src,
  output logic              irq_req
);
  logic [1:0]            rst_sync_q;
  logic                  rst_s;
  logic [NSRC-1:0]       en, frc, src_eff, chan_pend;
  logic                  av;
  logic [NSRC*SEL_W-1:0] map;
  logic                  win_any;
  logic [SEL_W-1:0]      win_id;
  logic                  pend_q, pend_d;
  logic [SEL_W-1:0]      id_q, id_d;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s = rst_sync_q[1];

  irqv_regs #(.N(NSRC), .SW(SEL_W)) u_regs (
    .clk(clk), .rst_n(rst_s), .wr_en(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .pend_i(pend_q), .id_i(id_q), .rdata(bus_rdata),
    .en_o(en), .frc_o(frc), .av_o(av), .map_o(map)
  );

  assign src_eff = irq_src | frc;

  irqv_route #(.N(NSRC), .SW(SEL_W)) u_route (
    .src(src_eff), .map(map), .en(en), .chan_pend(chan_pend)
  );

  irqv_pick #(.N(NSRC), .SW(SEL_W)) u_pick (
    .req(chan_pend), .any(win_any), .id(win_id)
  );

  always_comb begin
    pend_d = win_any;
    id_d   = win_id;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      pend_q <= 1'b0;
      id_q   <= '0;
    end else begin
      pend_q <= pend_d;
      id_q   <= id_d;
    end
  end

  assign irq_req = pend_q;

  assert_req_rise_R3: assert property (@(posedge clk) disable iff (!rst_s)
    (|chan_pend) |=> irq_req);
  assert_req_fall_R3: assert property (@(posedge clk) disable iff (!rst_s)
    !(|chan_pend) |=> !irq_req);
  assert_enable_gates_R2: assert property (@(posedge clk) disable iff (!rst_s)
    (chan_pend & ~en) == '0);
  assert_lowest_wins_R6: assert property (@(posedge clk) disable iff (!rst_s)
    win_any |-> (chan_pend[win_id] &&
                 ((chan_pend & ((NSRC'(1) << win_id) - NSRC'(1))) == '0)));
endmodule

// File: tb/irqv_ctrl_tb_top.sv
module irqv_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic        bus_wr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [63:0] irq_src;
  logic        irq_req;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 0;

  typedef struct {
    bit          is_irq;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb_q[$];
  event  mon_ev;

  always #(CLK_PERIOD/2) clk = ~clk;

  irqv_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_src(irq_src),
    .irq_req(irq_req)
  );

  // monitor: pops expected items and compares with what the design shows
  initial begin
    forever begin
      @(mon_ev);
      while (sb_q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it  = sb_q.pop_front();
        act = it.is_irq ? {31'b0, irq_req} : bus_rdata;
        n_checks++;
        if (act !== it.exp) begin
          n_fails++;
          $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = 8'h00; bus_wdata = '0;
  endtask

  task automatic exp_rd(logic [7:0] a, logic [31:0] e, string tag);
    item_t it;
    bus_addr = a;
    it.is_irq = 0; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    #1 -> mon_ev;
    #1;
  endtask

  task automatic exp_irq(bit e, string tag);
    item_t it;
    it.is_irq = 1; it.exp = {31'b0, e}; it.tag = tag;
    sb_q.push_back(it);
    #1 -> mon_ev;
    #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0; irq_src = '0;
    tick(3);
    rst_n = 1'b1;
    tick(4);

    // R1 reset state
    exp_rd(8'h10, 32'h0, "R1 enable lo");
    exp_rd(8'h28, 32'h0, "R1 enable hi");
    exp_rd(8'h08, 32'h0, "R1 force lo");
    exp_rd(8'h40, 32'h03020100, "R1 identity map word0");
    exp_rd(8'h7C, 32'h3F3E3D3C, "R1 identity map word15");
    exp_rd(8'h00, 32'h0, "R1 status");
    exp_irq(0, "R1 irq_req");

    // R2 disabled channel gives no request
    irq_src[5] = 1'b1;
    tick(2);
    exp_irq(0, "R2 disabled source");

    // R2 / R3 / R4 enable channel 5, auto-vector off
    wr(8'h10, 32'h0000_0220);
    exp_rd(8'h10, 32'h0000_0220, "R2 enable lo readback");
    tick(1);
    exp_irq(1, "R3 request on enabled source");
    exp_rd(8'h00, 32'h0000_0100, "R4 status without auto-vector");

    // R5 / R4 auto-vector on
    wr(8'h00, 32'h8000_0000);
    exp_rd(8'h00, 32'h8000_0105, "R5 R4 status with vector 5");

    // R3 level drop
    irq_src[5] = 1'b0;
    tick(1);
    exp_irq(0, "R3 drop after deassert");

    // R6 priority
    wr(8'h28, 32'h0000_0100);
    exp_rd(8'h28, 32'h0000_0100, "R2 enable hi readback");
    irq_src[9] = 1'b1; irq_src[40] = 1'b1;
    tick(1);
    exp_rd(8'h00, 32'h8000_0109, "R6 9 beats 40");
    irq_src[5] = 1'b1;
    tick(1);
    exp_rd(8'h00, 32'h8000_0105, "R6 5 beats 9");
    irq_src[5] = 1'b0; irq_src[9] = 1'b0;
    tick(1);
    exp_rd(8'h00, 32'h8000_0128, "R6 40 alone");
    irq_src[40] = 1'b0;
    tick(1);
    exp_rd(8'h00, 32'h8000_0000, "R4 nothing pending");

    // R7 remap channel 9 to source 63
    wr(8'h48, 32'h0B0A_FF08);
    exp_rd(8'h48, 32'h0B0A_3F08, "R7 map readback upper bits dropped");
    irq_src[63] = 1'b1;
    tick(1);
    exp_rd(8'h00, 32'h8000_0109, "R7 source 63 via channel 9");
    irq_src[63] = 1'b0; irq_src[9] = 1'b1;
    tick(1);
    exp_irq(0, "R7 source 9 no longer on channel 9");
    irq_src[9] = 1'b0;

    // R8 force
    wr(8'h20, 32'h0000_0100);
    exp_rd(8'h20, 32'h0000_0100, "R8 force hi readback");
    tick(1);
    exp_rd(8'h00, 32'h8000_0128, "R8 forced source 40");
    wr(8'h20, 32'h0);
    tick(1);
    exp_irq(0, "R8 force cleared");
    wr(8'h08, 32'h0000_0020);
    tick(1);
    exp_rd(8'h00, 32'h8000_0105, "R8 forced source 5");

    // R5 auto-vector off again hides the number
    wr(8'h00, 32'h0);
    exp_rd(8'h00, 32'h0000_0100, "R5 R4 auto-vector cleared");

    tick(2);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule